// File: doc/BRIEF.md
# Word-Operation Execution Unit

This unit executes the 32-bit "word" integer operations of a 64-bit integer datapath: add, subtract, shift left, logical shift right and arithmetic shift right. Each comes in a register-register form and a register-immediate form, except subtract, which has only the register form. The unit takes a 32-bit instruction word, two 64-bit source operands and the sign-extended 64-bit immediate. It works only on the low 32 bits of the operands and returns a 64-bit result, which is the 32-bit outcome sign-extended from bit 31.

A control module decodes the instruction into a small set of strobes. A datapath module forms the result from those strobes. The thin top can add one output register, chosen by a parameter. The unit raises a valid flag for a legal word operation and an illegal flag for an unsupported encoding in either word group. Instructions from any other major opcode pass through with both flags low, so a neighbouring unit can own them.

Top module: `word_exec_unit`

## Requirements
- R1: After reset, with no instruction driven, `result` is zero and `resValid` and `illegal` are low.
- R2: Only major opcode `instr[6:0]` = 0x3B (register form) or 0x1B (immediate form) is decoded. Any other opcode gives `resValid`=0, `illegal`=0 and `result`=0. The same holds when `inValid` is low.
- R3: `funct3` is `instr[14:12]` and `funct7` is `instr[31:25]`. With `funct3`=0, the unit adds `srcA[31:0]` and the second operand modulo 2^32. The second operand is `srcB[31:0]` in the register form and `immVal[31:0]` in the immediate form. In the register form, a nonzero `funct7` selects subtraction instead. No overflow flag is raised.
- R4: In the register form, `funct3`=1 shifts left and `funct3`=5 shifts right. The shift amount is `srcB[4:0]` only, so bit 5 and above of `srcB` have no effect.
- R5: In the immediate form, shifts (`funct3`=1 or 5) use `immVal[4:0]` as the amount. If `immVal[5]`=1, the instruction is illegal.
- R6: A right shift is arithmetic (sign-filling from bit 31) when `funct7` is nonzero. In the immediate form, `funct7` bit 0 is ignored for this test. Otherwise the right shift is logical (zero-filling).
- R7: Every legal result has bits [63:32] equal to copies of bit 31 of the 32-bit outcome. This includes logical right shifts: a logical right shift of 0x80000000 by 0 gives 0xFFFFFFFF80000000.
- R8: Bits [63:32] of `srcA` and `srcB` never affect the result.
- R9: In either word group, a `funct3` other than 0, 1 or 5 raises `illegal`, with `resValid`=0 and `result`=0.
- R10: For immediate shifts, the unit masks off `funct7` bit 0. If the masked value is neither 0x00 nor 0x20, the unit raises `illegal`, with `resValid`=0 and `result`=0.
- R11: With the default `REG_OUT`=1, outputs appear one clock after the inputs are presented. `resValid` and `illegal` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| srcA | input | XLEN (64) | First source operand |
| srcB | input | XLEN (64) | Second source operand (register form) |
| immVal | input | XLEN (64) | Sign-extended immediate (immediate form) |
| result | output | XLEN (64) | Sign-extended word result, zero unless valid |
| resValid | output | 1 | A legal word operation produced `result` |
| illegal | output | 1 | Unsupported word-group encoding |

## Verification
On every cycle, the assertions check the following properties:
- the two flags are mutually exclusive;
- an illegal output carries a zero result;
- every valid result is properly sign-extended above bit 31;
- a flag is raised only for the two word opcodes;
- `resValid` only follows a cycle with `inValid` high.

The arithmetic itself can only be shown by the bench scenarios, which compare against an independent model. These include:
- the 5-bit shift truncation;
- arithmetic versus logical fill;
- modulo-2^32 wrap;
- the immunity of the upper operand halves;
- the exact illegal cases in the immediate shift encodings.

// File: rtl/wordop_pkg.sv
package wordop_pkg;

  localparam logic [6:0] OPC_REG_WORD = 7'h3B;
  localparam logic [6:0] OPC_IMM_WORD = 7'h1B;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_SLL = 3'd2,
    OP_SRL = 3'd3,
    OP_SRA = 3'd4
  } wordOpE;

  typedef struct packed {
    wordOpE op;
    logic   useImm;
    logic   legal;
    logic   bad;
  } ctrlStrobesT;

endpackage

// File: rtl/word_ctrl.sv
module word_ctrl
  import wordop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  input  logic        immBit5,
  output ctrlStrobesT strobes
);

  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic [6:0] funct7Masked;
  logic       isReg;
  logic       isImm;
  logic       inGroup;
  logic       knownF3;
  logic       shImmBad;
  logic       arith;
  wordOpE     opSel;
  logic       unusedInstrBits;

  assign opcode       = instr[6:0];
  assign funct3       = instr[14:12];
  assign funct7       = instr[31:25];
  assign funct7Masked = {funct7[6:1], 1'b0};
  assign isReg        = (opcode == OPC_REG_WORD);
  assign isImm        = (opcode == OPC_IMM_WORD);
  assign inGroup      = inValid && (isReg || isImm);
  assign unusedInstrBits = ^{instr[24:15], instr[11:7]};

  always_comb begin
    knownF3 = 1'b1;
    arith   = isReg ? (funct7 != 7'd0) : (funct7Masked != 7'd0);
    opSel   = OP_ADD;
    case (funct3)
      3'd0: opSel = (isReg && (funct7 != 7'd0)) ? OP_SUB : OP_ADD;
      3'd1: opSel = OP_SLL;
      3'd5: opSel = arith ? OP_SRA : OP_SRL;
      default: knownF3 = 1'b0;
    endcase
  end

  assign shImmBad = isImm && (funct3 != 3'd0) &&
                    (immBit5 || ((funct7Masked != 7'd0) && (funct7Masked != 7'h20)));

  always_comb begin
    strobes.op     = opSel;
    strobes.useImm = isImm;
    strobes.legal  = inGroup && knownF3 && !shImmBad;
    strobes.bad    = inGroup && (!knownF3 || shImmBad);
  end

  // R2
  decode_grp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.legal || strobes.bad) |-> (inValid && (isReg || isImm)));

endmodule

// File: rtl/word_datapath.sv
module word_datapath
  import wordop_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobesT     strobes,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [XLEN-1:0] immVal,
  output logic [XLEN-1:0] dpResult
);

  localparam int SHW = $clog2(WLEN);
  localparam int EXTW = XLEN - WLEN;

  logic [WLEN-1:0] wordA;
  logic [WLEN-1:0] wordB;
  logic [SHW-1:0]  shAmt;
  logic [WLEN-1:0] wordR;
  logic            unusedHiBits;

  assign wordA = srcA[WLEN-1:0];
  assign wordB = strobes.useImm ? immVal[WLEN-1:0] : srcB[WLEN-1:0];
  assign shAmt = wordB[SHW-1:0];
  assign unusedHiBits = ^{srcA[XLEN-1:WLEN], srcB[XLEN-1:WLEN], immVal[XLEN-1:WLEN]};

  always_comb begin
    case (strobes.op)
      OP_SUB:  wordR = wordA - wordB;
      OP_SLL:  wordR = wordA << shAmt;
      OP_SRL:  wordR = wordA >> shAmt;
      OP_SRA:  wordR = WLEN'($signed(wordA) >>> shAmt);
      default: wordR = wordA + wordB;
    endcase
  end

  assign dpResult = strobes.legal ? {{EXTW{wordR[WLEN-1]}}, wordR} : '0;

  // R7
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.legal |-> (dpResult[XLEN-1:WLEN] == {EXTW{dpResult[WLEN-1]}}));

endmodule

// File: rtl/word_exec_unit.sv
module word_exec_unit
  import wordop_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WLEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [XLEN-1:0] immVal,
  output logic [XLEN-1:0] result,
  output logic            resValid,
  output logic            illegal
);

  ctrlStrobesT     strobes;
  logic [XLEN-1:0] dpResult;

  word_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .instr   (instr),
    .immBit5 (immVal[5]),
    .strobes (strobes)
  );

  word_datapath #(.XLEN(XLEN), .WLEN(WLEN)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .srcA     (srcA),
    .srcB     (srcB),
    .immVal   (immVal),
    .dpResult (dpResult)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          result   <= '0;
          resValid <= 1'b0;
          illegal  <= 1'b0;
        end else begin
          result   <= dpResult;
          resValid <= strobes.legal;
          illegal  <= strobes.bad;
        end
      end

      // R11
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
        resValid |-> $past(inValid));
    end else begin : g_comb
      assign result   = dpResult;
      assign resValid = strobes.legal;
      assign illegal  = strobes.bad;
    end
  endgenerate

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && illegal));

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (result == '0));

endmodule

// File: tb/word_exec_unit_tb_top.sv
`timescale 1ns/1ps
module word_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [63:0] immVal = '0;
  logic [63:0] result;
  logic        resValid;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  word_exec_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .immVal(immVal),
    .result(result), .resValid(resValid), .illegal(illegal)
  );

  function automatic logic [31:0] mkR(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [31:0] mkI(logic [11:0] imm, logic [2:0] f3, logic [6:0] opc);
    return {imm, 5'd1, f3, 5'd3, opc};
  endfunction

  // expected {valid, illegal, result} from the requirements
  function automatic logic [65:0] model(logic v, logic [31:0] ins, logic [63:0] a,
                                        logic [63:0] b, logic [63:0] im);
    logic [6:0]  opc = ins[6:0];
    logic [2:0]  f3  = ins[14:12];
    logic [6:0]  f7  = ins[31:25];
    logic [6:0]  f7m = {ins[31:26], 1'b0};
    logic        isR = (opc == 7'h3B);
    logic [31:0] x   = a[31:0];
    logic [31:0] y   = isR ? b[31:0] : im[31:0];
    logic [31:0] r   = '0;
    if (!v || !(isR || opc == 7'h1B)) return '0;
    if (!(f3 == 3'd0 || f3 == 3'd1 || f3 == 3'd5)) return {1'b0, 1'b1, 64'd0};
    if (!isR && f3 != 3'd0 && (im[5] || (f7m != 7'd0 && f7m != 7'h20)))
      return {1'b0, 1'b1, 64'd0};
    if (f3 == 3'd0) r = (isR && f7 != 0) ? x - y : x + y;
    else if (f3 == 3'd1) r = x << y[4:0];
    else if ((isR ? f7 != 0 : f7m != 0)) r = 32'($signed(x) >>> y[4:0]);
    else r = x >> y[4:0];
    return {1'b1, 1'b0, {{32{r[31]}}, r}};
  endfunction

  task automatic check(string tag, logic [63:0] er, logic ev, logic ei);
    checks++;
    if (result !== er || resValid !== ev || illegal !== ei) begin
      errors++;
      $display("FAIL %s: got res=%h v=%b ill=%b exp res=%h v=%b ill=%b",
               tag, result, resValid, illegal, er, ev, ei);
    end
  endtask

  task automatic run(string tag, logic v, logic [31:0] ins, logic [63:0] a, logic [63:0] b);
    logic [65:0] e;
    @(negedge clk);
    inValid = v; instr = ins; srcA = a; srcB = b;
    immVal = {{52{ins[31]}}, ins[31:20]};
    e = model(v, ins, a, b, immVal);
    @(negedge clk);
    check(tag, e[63:0], e[65], e[64]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", 64'd0, 1'b0, 1'b0);

    // R2 foreign opcode and idle input
    run("R2 foreign", 1'b1, mkR(7'h00, 3'd0, 7'h33), 64'd5, 64'd6);
    check("R2 foreign exp", 64'd0, 1'b0, 1'b0);
    run("R2 idle", 1'b0, mkR(7'h00, 3'd0, 7'h3B), 64'd5, 64'd6);
    check("R2 idle exp", 64'd0, 1'b0, 1'b0);

    // R3 wrap add, sub, immediate add
    run("R3 addw wrap", 1'b1, mkR(7'h00, 3'd0, 7'h3B), 64'h0000_0000_7FFF_FFFF, 64'd1);
    check("R3 addw exp", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
    run("R3 subw", 1'b1, mkR(7'h20, 3'd0, 7'h3B), 64'd0, 64'd1);
    check("R3 subw exp", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    run("R3 addiw", 1'b1, mkI(12'hFFF, 3'd0, 7'h1B), 64'd0, 64'd0);
    check("R3 addiw exp", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);

    // R4 shift amount only srcB[4:0]
    run("R4 sllw", 1'b1, mkR(7'h00, 3'd1, 7'h3B), 64'd1, 64'hFFFF_FFFF_FFFF_FFE1);
    check("R4 sllw exp", 64'd2, 1'b1, 1'b0);

    // R5 immediate shift by 31, and imm[5] illegal
    run("R5 slliw", 1'b1, mkI(12'h01F, 3'd1, 7'h1B), 64'd1, 64'd0);
    check("R5 slliw exp", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
    run("R5 imm5", 1'b1, mkI(12'h021, 3'd1, 7'h1B), 64'd1, 64'd0);
    check("R5 imm5 exp", 64'd0, 1'b0, 1'b1);

    // R6 arithmetic vs logical
    run("R6 sraw", 1'b1, mkR(7'h20, 3'd5, 7'h3B), 64'h8000_0000, 64'd4);
    check("R6 sraw exp", 64'hFFFF_FFFF_F800_0000, 1'b1, 1'b0);
    run("R6 srlw", 1'b1, mkR(7'h00, 3'd5, 7'h3B), 64'h8000_0000, 64'd4);
    check("R6 srlw exp", 64'h0000_0000_0800_0000, 1'b1, 1'b0);
    run("R6 sraiw", 1'b1, mkI(12'h408, 3'd5, 7'h1B), 64'h8000_0000, 64'd0);
    check("R6 sraiw exp", 64'hFFFF_FFFF_FF80_0000, 1'b1, 1'b0);

    // R7 logical shift by zero still sign-extends
    run("R7 srlw0", 1'b1, mkR(7'h00, 3'd5, 7'h3B), 64'h8000_0000, 64'd0);
    check("R7 srlw0 exp", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);

    // R8 upper halves ignored
    run("R8 upper", 1'b1, mkR(7'h00, 3'd0, 7'h3B), 64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0003);
    check("R8 upper exp", 64'd8, 1'b1, 1'b0);

    // R9 unsupported funct3
    run("R9 reg f3", 1'b1, mkR(7'h00, 3'd2, 7'h3B), 64'd1, 64'd1);
    check("R9 reg f3 exp", 64'd0, 1'b0, 1'b1);
    run("R9 imm f3", 1'b1, mkI(12'h001, 3'd7, 7'h1B), 64'd1, 64'd1);
    check("R9 imm f3 exp", 64'd0, 1'b0, 1'b1);

    // R10 bad funct7 on immediate shift
    run("R10 f7", 1'b1, mkI(12'h204, 3'd5, 7'h1B), 64'd16, 64'd0);
    check("R10 f7 exp", 64'd0, 1'b0, 1'b1);

    // R11 one-cycle latency
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    inValid = 1'b1; instr = mkR(7'h00, 3'd0, 7'h3B); srcA = 64'd7; srcB = 64'd9;
    immVal = '0;
    #1 check("R11 before edge", 64'd0, 1'b0, 1'b0);
    @(negedge clk);
    check("R11 after edge", 64'd16, 1'b1, 1'b0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ins;
      logic [6:0]  opc;
      logic [2:0]  f3;
      logic [6:0]  f7;
      int          sel;
      sel = int'($urandom % 5);
      opc = (sel < 2) ? 7'h3B : (sel < 4) ? 7'h1B : 7'h13;
      f3  = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 3 == 0) ? 3'd0 : ($urandom % 2 == 0) ? 3'd1 : 3'd5);
      sel = int'($urandom % 4);
      f7  = (sel == 0) ? 7'h00 : (sel == 1) ? 7'h20 : (sel == 2) ? 7'h01 : 7'($urandom);
      ins = {f7, 5'($urandom), 5'($urandom), f3, 5'($urandom), opc};
      run("RAND", ($urandom % 8) != 0, ins, {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule